// File: doc/BRIEF.md
# Clock Root Select and Divider Enable Chain

This block picks one of three root clock sources and derives four clock enables from it: a CPU enable, a bus (AHB) enable, a peripheral (APB) enable and a fast memory-interface enable. All logic runs in a single fast reference domain. Each source is a one-cycle tick input, and each derived clock is a one-cycle enable pulse at the divided rate. There is no gated clock. The sources are a crystal, a PLL and an internal fast RC oscillator. On the PLL path the CPU and bus clocks see a fixed divide-by-3 ahead of their own post-dividers. On the slow paths that fixed stage is a pass-through. A special CPU mode reaches a total ratio of 4 from the PLL, a ratio that the divide-by-3 stage cannot otherwise produce.

The source select and every divider field are loaded through one configuration write. A write is accepted only if its select is legal and every field that its select uses is legal. A rejected write leaves all settings untouched and raises a sticky error. An accepted write is held until every enable counter completes its period on the same source tick. At that boundary the new setting takes over and all counters restart together. For this reason no pulse is ever cut short or doubled. Four readback outputs give the total ratio of each enable with respect to the root ticks, for the setting in force.

Top module: `clkroot_divchain`

## Requirements
- R1: After reset the root is the crystal, all four readback ratios are 1, the error flag is 0, and no write is pending.
- R2: The select lies in config bits [1:0], coded 0 = crystal, 1 = PLL, 2 = fast RC. Enables advance only on ticks of the selected source. Ticks of the other sources have no effect.
- R3: With the PLL selected, the CPU field lies in bits [3:2] and accepts the values 0, 1 and 3. These give CPU ratios of 3, 6 and 12.
- R4: The force bit is bit [4]. It gives a CPU ratio of 4 only when the PLL is selected and bits [3:2] are 0. In every other case it has no effect.
- R5: With the crystal or RC selected, the CPU field is bits [9:5] and the bus field is bits [18:14]. Each accepts 0, 1, 3, 7, 15 or 31, and the ratio is the field value plus 1.
- R6: With the PLL selected, the bus field lies in bits [13:10] and accepts the values 3, 7 and 15. These give bus ratios of 12, 24 and 48.
- R7: The APB field is bits [20:19] and accepts 0, 1 or 3. The APB ratio is the bus ratio times (field + 1). Every APB pulse coincides with a bus pulse.
- R8: The memory-interface ratio is counted directly from root ticks. With the PLL selected, the field is bits [23:21], and the values 3, 4 and 5 give ratios 4, 5 and 6. With a slow source selected, the field is bits [25:24], and the values 0, 1 and 2 give ratios 1, 2 and 4.
- R9: A write whose select is 3, whose APB field is 2, or whose used-path fields lie outside their legal sets is rejected. The error flag rises on the next cycle and then stays set. The active and pending settings do not change. Fields of the path that the select does not use are not checked.
- R10: An accepted write becomes active on the first selected-source tick at which all four counters are at their last count. The readback changes on the following cycle, and all counters restart from zero.
- R11: Each enable is high exactly on the selected-source ticks that complete its ratio, counted from reset or from the last commit.
- R12: The readback ratios always report the setting that is in force, never a pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | Crystal source tick |
| pll_tick | input | 1 | PLL source tick |
| rcf_tick | input | 1 | Fast RC source tick |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 26 | Configuration word (field layout per requirements) |
| cpu_en | output | 1 | CPU clock enable pulse |
| ahb_en | output | 1 | Bus clock enable pulse |
| apb_en | output | 1 | Peripheral clock enable pulse |
| mem_en | output | 1 | Memory-interface clock enable pulse |
| cpu_ratio | output | 8 | Active CPU total ratio |
| ahb_ratio | output | 8 | Active bus total ratio |
| apb_ratio | output | 8 | Active APB total ratio |
| mem_ratio | output | 8 | Active memory-interface total ratio |
| cfg_err | output | 1 | Sticky rejected-write flag |

## Verification
Each enable is a combinational function of the selected tick and the registered counter state. It is due in the same cycle as the source tick that completes a period. The bench drives inputs just after the rising edge and compares every enable at the falling edge of that same cycle. This comparison is made against a bench-side model that advances at each rising edge. The error flag and the readback ratios are registered. The error flag is due one cycle after a rejected write. The readback ratios are due one cycle after the boundary tick. Both are compared every cycle against the same model, so that a commit one cycle early or late is seen as a miscompare. Directed phases use constant ticks and wait longer than the largest common period (960 ticks). They then check the readback against fixed constants and count pulses over whole periods.

// File: rtl/crd_pkg.sv
`timescale 1ns/1ps
package crd_pkg;

  localparam int unsigned CFG_W   = 26;
  localparam int unsigned RATIO_W = 8;
  localparam int unsigned NCLK    = 4;
  localparam int unsigned PLL_PRE = 3;

  typedef enum logic [1:0] {
    ROOT_XTAL = 2'd0,
    ROOT_PLL  = 2'd1,
    ROOT_RCF  = 2'd2,
    ROOT_BAD  = 2'd3
  } root_e;

  typedef struct packed {
    logic [1:0] mem_ls;
    logic [2:0] mem_hs;
    logic [1:0] apb;
    logic [4:0] ahb_ls;
    logic [3:0] ahb_hs;
    logic [4:0] cpu_ls;
    logic       cpu_fast4;
    logic [1:0] cpu_hs;
    root_e      sel;
  } clkcfg_t;

  typedef logic [RATIO_W-1:0] ratio_t;

  function automatic logic is_pow2m1(input logic [4:0] f);
    return (f & (f + 5'd1)) == 5'd0;
  endfunction

  function automatic logic cfg_legal(input clkcfg_t c);
    logic ok;
    ok = (c.apb != 2'd2);
    case (c.sel)
      ROOT_PLL: ok = ok && (c.cpu_hs != 2'd2)
                        && (c.ahb_hs inside {4'd3, 4'd7, 4'd15})
                        && (c.mem_hs inside {3'd3, 3'd4, 3'd5});
      ROOT_XTAL,
      ROOT_RCF: ok = ok && is_pow2m1(c.cpu_ls) && is_pow2m1(c.ahb_ls)
                        && (c.mem_ls != 2'd3);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic ratio_t cpu_total(input clkcfg_t c);
    if (c.sel == ROOT_PLL) begin
      if (c.cpu_fast4 && (c.cpu_hs == 2'd0)) return ratio_t'(4);
      return ratio_t'(PLL_PRE) * (ratio_t'(c.cpu_hs) + ratio_t'(1));
    end
    return ratio_t'(c.cpu_ls) + ratio_t'(1);
  endfunction

  function automatic ratio_t ahb_total(input clkcfg_t c);
    if (c.sel == ROOT_PLL)
      return ratio_t'(PLL_PRE) * (ratio_t'(c.ahb_hs) + ratio_t'(1));
    return ratio_t'(c.ahb_ls) + ratio_t'(1);
  endfunction

  function automatic ratio_t apb_total(input clkcfg_t c);
    return ahb_total(c) * (ratio_t'(c.apb) + ratio_t'(1));
  endfunction

  function automatic ratio_t mem_total(input clkcfg_t c);
    if (c.sel == ROOT_PLL) return ratio_t'(c.mem_hs) + ratio_t'(1);
    if (c.mem_ls == 2'd2)  return ratio_t'(4);
    return ratio_t'(c.mem_ls) + ratio_t'(1);
  endfunction

endpackage

// File: rtl/crd_root_mux.sv
`timescale 1ns/1ps
module crd_root_mux
  import crd_pkg::*;
(
  input  root_e sel,
  input  logic  xtal_tick,
  input  logic  pll_tick,
  input  logic  rcf_tick,
  output logic  root_tick
);
  always_comb begin
    case (sel)
      ROOT_XTAL: root_tick = xtal_tick;
      ROOT_PLL:  root_tick = pll_tick;
      ROOT_RCF:  root_tick = rcf_tick;
      default:   root_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/crd_tick_div.sv
`timescale 1ns/1ps
module crd_tick_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic [W-1:0] cnt,
  output logic         at_last,
  output logic         pulse
);
  logic [W-1:0] cnt_q;

  assign at_last = (cnt_q == ratio - W'(1));
  assign pulse   = tick & at_last;
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= at_last ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/crd_cfg_hold.sv
`timescale 1ns/1ps
module crd_cfg_hold
  import crd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  clkcfg_t wr_data,
  input  logic    boundary,
  output clkcfg_t act,
  output logic    wr_ok,
  output logic    commit,
  output logic    err
);
  clkcfg_t act_q, pend_q;
  logic    pend_v, err_q;

  assign wr_ok  = cfg_legal(wr_data);
  assign commit = pend_v & boundary;
  assign act    = act_q;
  assign err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (commit) begin
        act_q  <= pend_q;
        pend_v <= 1'b0;
      end
      if (wr_en) begin
        if (wr_ok) begin
          pend_q <= wr_data;
          pend_v <= 1'b1;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clkroot_divchain.sv
`timescale 1ns/1ps
module clkroot_divchain
  import crd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xtal_tick,
  input  logic                 pll_tick,
  input  logic                 rcf_tick,
  input  logic                 cfg_wr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic                 cpu_en,
  output logic                 ahb_en,
  output logic                 apb_en,
  output logic                 mem_en,
  output logic [RATIO_W-1:0]   cpu_ratio,
  output logic [RATIO_W-1:0]   ahb_ratio,
  output logic [RATIO_W-1:0]   apb_ratio,
  output logic [RATIO_W-1:0]   mem_ratio,
  output logic                 cfg_err
);
  localparam int unsigned RW     = RATIO_W;
  localparam int unsigned IX_CPU = 0;
  localparam int unsigned IX_AHB = 1;
  localparam int unsigned IX_APB = 2;
  localparam int unsigned IX_MEM = 3;

  clkcfg_t         act;
  logic            wr_ok, commit, root_tick, boundary, cnt_all_zero;
  logic [1:0]      act_sel;
  logic [RW-1:0]   ratio_a [NCLK];
  logic [RW-1:0]   cnt_a   [NCLK];
  logic [NCLK-1:0] last_v, en_v;

  crd_cfg_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_data  (clkcfg_t'(cfg_wdata)),
    .boundary (boundary),
    .act      (act),
    .wr_ok    (wr_ok),
    .commit   (commit),
    .err      (cfg_err)
  );

  crd_root_mux u_mux (
    .sel       (act.sel),
    .xtal_tick (xtal_tick),
    .pll_tick  (pll_tick),
    .rcf_tick  (rcf_tick),
    .root_tick (root_tick)
  );

  assign act_sel         = act.sel;
  assign ratio_a[IX_CPU] = cpu_total(act);
  assign ratio_a[IX_AHB] = ahb_total(act);
  assign ratio_a[IX_APB] = apb_total(act);
  assign ratio_a[IX_MEM] = mem_total(act);

  for (genvar g = 0; g < NCLK; g++) begin : g_div
    crd_tick_div #(.W(RW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (root_tick),
      .ratio   (ratio_a[g]),
      .cnt     (cnt_a[g]),
      .at_last (last_v[g]),
      .pulse   (en_v[g])
    );
  end

  // common period boundary: every counter wraps on this tick
  assign boundary = root_tick & (&last_v);

  always_comb begin
    cnt_all_zero = 1'b1;
    for (int i = 0; i < NCLK; i++)
      if (cnt_a[i] != '0) cnt_all_zero = 1'b0;
  end

  assign cpu_en    = en_v[IX_CPU];
  assign ahb_en    = en_v[IX_AHB];
  assign apb_en    = en_v[IX_APB];
  assign mem_en    = en_v[IX_MEM];
  assign cpu_ratio = ratio_a[IX_CPU];
  assign ahb_ratio = ratio_a[IX_AHB];
  assign apb_ratio = ratio_a[IX_APB];
  assign mem_ratio = ratio_a[IX_MEM];
endmodule

// File: rtl/crd_chk.sv
`timescale 1ns/1ps
module crd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       root_tick,
  input logic       cpu_en,
  input logic       ahb_en,
  input logic       apb_en,
  input logic       mem_en,
  input logic [7:0] cpu_ratio,
  input logic [7:0] apb_ratio,
  input logic [7:0] mem_ratio,
  input logic       cfg_wr,
  input logic       cfg_err,
  input logic       wr_ok,
  input logic       commit,
  input logic       cnt_all_zero,
  input logic [1:0] act_sel
);
  a_r7_apb_inside_ahb: assert property (@(posedge clk) disable iff (!rst_n)
    apb_en |-> ahb_en);

  a_r2_enable_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en | ahb_en | apb_en | mem_en) |-> root_tick);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r9_err_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !wr_ok) |=> cfg_err);

  a_r10_ratio_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_ratio != $past(cpu_ratio)) || (apb_ratio != $past(apb_ratio))
     || (mem_ratio != $past(mem_ratio))) |-> $past(commit));

  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cnt_all_zero);

  a_r3_pll_cpu_set: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel == 2'd1) |-> (cpu_ratio inside {8'd3, 8'd4, 8'd6, 8'd12}));

  a_r8_pll_mem_set: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel == 2'd1) |-> (mem_ratio inside {8'd4, 8'd5, 8'd6}));
endmodule

bind clkroot_divchain crd_chk u_crd_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .root_tick    (root_tick),
  .cpu_en       (cpu_en),
  .ahb_en       (ahb_en),
  .apb_en       (apb_en),
  .mem_en       (mem_en),
  .cpu_ratio    (cpu_ratio),
  .apb_ratio    (apb_ratio),
  .mem_ratio    (mem_ratio),
  .cfg_wr       (cfg_wr),
  .cfg_err      (cfg_err),
  .wr_ok        (wr_ok),
  .commit       (commit),
  .cnt_all_zero (cnt_all_zero),
  .act_sel      (act_sel)
);

// File: tb/clkroot_divchain_tb_top.sv
`timescale 1ns/1ps
module clkroot_divchain_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xtal_tick = 1'b0, pll_tick = 1'b0, rcf_tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [25:0] cfg_wdata = '0;
  logic        cpu_en, ahb_en, apb_en, mem_en, cfg_err;
  logic [7:0]  cpu_ratio, ahb_ratio, apb_ratio, mem_ratio;

  int  n_vec = 0, n_bad = 0;
  bit  mon_on = 1'b0, done = 1'b0;
  bit  on_x = 1'b1, on_p = 1'b1, on_r = 1'b1, rnd_ticks = 1'b0;

  always #4 clk = ~clk;

  clkroot_divchain dut_i (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .pll_tick(pll_tick),
    .rcf_tick(rcf_tick), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cpu_en(cpu_en), .ahb_en(ahb_en), .apb_en(apb_en), .mem_en(mem_en),
    .cpu_ratio(cpu_ratio), .ahb_ratio(ahb_ratio), .apb_ratio(apb_ratio),
    .mem_ratio(mem_ratio), .cfg_err(cfg_err)
  );

  // ---------------- bench-side arithmetic, from the requirements
  function automatic int b_cpu(bit [25:0] w);
    if (w[1:0] == 2'd1) begin
      case (w[3:2])
        2'd0:    return w[4] ? 4 : 3;
        2'd1:    return 6;
        2'd3:    return 12;
        default: return 0;
      endcase
    end
    return int'(w[9:5]) + 1;
  endfunction

  function automatic int b_ahb(bit [25:0] w);
    if (w[1:0] == 2'd1) return 3 * (int'(w[13:10]) + 1);
    return int'(w[18:14]) + 1;
  endfunction

  function automatic int b_apb(bit [25:0] w);
    return b_ahb(w) * (int'(w[20:19]) + 1);
  endfunction

  function automatic int b_mem(bit [25:0] w);
    if (w[1:0] == 2'd1) return int'(w[23:21]) + 1;
    case (w[25:24])
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit b_p2(int v);
    return v == 0 || v == 1 || v == 3 || v == 7 || v == 15 || v == 31;
  endfunction

  function automatic bit b_legal(bit [25:0] w);
    if (w[1:0] == 2'd3 || w[20:19] == 2'd2) return 1'b0;
    if (w[1:0] == 2'd1)
      return (w[3:2] != 2'd2) && (w[13:10] == 3 || w[13:10] == 7 || w[13:10] == 15)
             && (w[23:21] >= 3 && w[23:21] <= 5);
    return b_p2(int'(w[9:5])) && b_p2(int'(w[18:14])) && (w[25:24] != 2'd3);
  endfunction

  function automatic bit [25:0] mk(bit [1:0] sel, bit [1:0] chs, bit f4, bit [4:0] cls,
                                   bit [3:0] ahs, bit [4:0] als, bit [1:0] apb,
                                   bit [2:0] mhs, bit [1:0] mls);
    return {mls, mhs, apb, als, ahs, cls, f4, chs, sel};
  endfunction

  function automatic bit b_tick(bit [25:0] w, logic x, logic p, logic r);
    case (w[1:0])
      2'd0: return x;
      2'd1: return p;
      2'd2: return r;
      default: return 1'b0;
    endcase
  endfunction

  // ---------------- reference model
  bit [25:0] m_act, m_pend;
  bit        m_pv, m_err;
  int        m_cnt [4];
  int        m_rat [4];
  bit        m_tk, m_all;

  function automatic void ratios_of(bit [25:0] w, output int r[4]);
    r[0] = b_cpu(w); r[1] = b_ahb(w); r[2] = b_apb(w); r[3] = b_mem(w);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= '0; m_pend <= '0; m_pv <= 1'b0; m_err <= 1'b0;
      for (int i = 0; i < 4; i++) m_cnt[i] <= 0;
    end else begin
      ratios_of(m_act, m_rat);
      m_tk  = b_tick(m_act, xtal_tick, pll_tick, rcf_tick);
      m_all = m_tk;
      for (int i = 0; i < 4; i++) if (m_cnt[i] != m_rat[i] - 1) m_all = 1'b0;
      if (m_tk)
        for (int i = 0; i < 4; i++) m_cnt[i] <= (m_cnt[i] == m_rat[i] - 1) ? 0 : m_cnt[i] + 1;
      if (m_pv && m_all) begin m_act <= m_pend; m_pv <= 1'b0; end
      if (cfg_wr) begin
        if (b_legal(cfg_wdata)) begin m_pend <= cfg_wdata; m_pv <= 1'b1; end
        else m_err <= 1'b1;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && mon_on && !done) begin
      int  r[4];
      bit  tk;
      ratios_of(m_act, r);
      tk = b_tick(m_act, xtal_tick, pll_tick, rcf_tick);
      chk("R11/R2 cpu_en", int'(cpu_en), int'(tk && m_cnt[0] == r[0] - 1));
      chk("R11/R2 ahb_en", int'(ahb_en), int'(tk && m_cnt[1] == r[1] - 1));
      chk("R11/R7 apb_en", int'(apb_en), int'(tk && m_cnt[2] == r[2] - 1));
      chk("R11/R8 mem_en", int'(mem_en), int'(tk && m_cnt[3] == r[3] - 1));
      chk("R12/R10 cpu_ratio", int'(cpu_ratio), r[0]);
      chk("R12/R10 ahb_ratio", int'(ahb_ratio), r[1]);
      chk("R12/R10 apb_ratio", int'(apb_ratio), r[2]);
      chk("R12/R10 mem_ratio", int'(mem_ratio), r[3]);
      chk("R9 cfg_err", int'(cfg_err), int'(m_err));
    end
  end

  // source tick drivers
  initial begin
    forever begin
      @(posedge clk); #1;
      xtal_tick = on_x && (!rnd_ticks || ($urandom % 4 != 0));
      pll_tick  = on_p && (!rnd_ticks || ($urandom % 8 != 0));
      rcf_tick  = on_r && (!rnd_ticks || ($urandom % 3 != 0));
    end
  end

  task automatic write_cfg(bit [25:0] w);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = w;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (1000) @(posedge clk);
  endtask

  task automatic count_en(int n, output int c_cpu, output int c_mem);
    c_cpu = 0; c_mem = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_cpu += int'(cpu_en);
      c_mem += int'(mem_en);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  function automatic bit [25:0] rand_cfg();
    int ls [6] = '{0, 1, 3, 7, 15, 31};
    int chs[3] = '{0, 1, 3};
    int ahs[3] = '{3, 7, 15};
    int apb[3] = '{0, 1, 3};
    bit [25:0] w;
    w = 26'($urandom);
    if ($urandom % 7 == 0) return w;
    w[1:0]   = 2'($urandom % 3);
    w[3:2]   = 2'(chs[$urandom % 3]);
    w[9:5]   = 5'(ls[$urandom % 6]);
    w[13:10] = 4'(ahs[$urandom % 3]);
    w[18:14] = 5'(ls[$urandom % 6]);
    w[20:19] = 2'(apb[$urandom % 3]);
    w[23:21] = 3'(3 + $urandom % 3);
    w[25:24] = 2'($urandom % 3);
    return w;
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int c1, c2;
    void'($urandom(32'd20417));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cpu_ratio", int'(cpu_ratio), 1);
    chk("R1 ahb_ratio", int'(ahb_ratio), 1);
    chk("R1 apb_ratio", int'(apb_ratio), 1);
    chk("R1 mem_ratio", int'(mem_ratio), 1);
    chk("R1 cfg_err", int'(cfg_err), 0);
    mon_on = 1'b1;

    // R3 R6 R8: PLL, cpu /3, ahb /12, mem /4
    write_cfg(mk(2'd1, 2'd0, 1'b0, 5'd0, 4'd3, 5'd0, 2'd0, 3'd3, 2'd0));
    settle();
    chk("R3 cpu_ratio pll", int'(cpu_ratio), 3);
    chk("R6 ahb_ratio pll", int'(ahb_ratio), 12);
    chk("R8 mem_ratio pll", int'(mem_ratio), 4);
    count_en(120, c1, c2);
    chk("R3 cpu pulses in 120", c1, 40);
    chk("R8 mem pulses in 120", c2, 30);

    // R4 force honoured
    write_cfg(mk(2'd1, 2'd0, 1'b1, 5'd0, 4'd7, 5'd0, 2'd1, 3'd5, 2'd0));
    settle();
    chk("R4 cpu_ratio forced", int'(cpu_ratio), 4);
    chk("R7 apb_ratio 24x2", int'(apb_ratio), 48);
    count_en(120, c1, c2);
    chk("R4 cpu pulses in 120", c1, 30);
    chk("R8 mem pulses in 120", c2, 20);

    // R4 force ignored with nonzero field; R7 APB x4 of /48
    write_cfg(mk(2'd1, 2'd1, 1'b1, 5'd0, 4'd15, 5'd0, 2'd3, 3'd4, 2'd0));
    settle();
    chk("R4 cpu_ratio not forced", int'(cpu_ratio), 6);
    chk("R7 apb_ratio 48x4", int'(apb_ratio), 192);
    chk("R8 mem_ratio /5", int'(mem_ratio), 5);

    // R5 slow path, force ignored; R8 slow field 2 -> 4
    write_cfg(mk(2'd0, 2'd3, 1'b1, 5'd31, 4'd0, 5'd7, 2'd1, 3'd0, 2'd2));
    settle();
    chk("R5 cpu_ratio /32", int'(cpu_ratio), 32);
    chk("R5 ahb_ratio /8", int'(ahb_ratio), 8);
    chk("R7 apb_ratio 8x2", int'(apb_ratio), 16);
    chk("R8 mem_ratio slow 2", int'(mem_ratio), 4);

    // R2 RC source, then only foreign ticks
    write_cfg(mk(2'd2, 2'd0, 1'b0, 5'd1, 4'd0, 5'd0, 2'd0, 3'd0, 2'd0));
    settle();
    on_x = 1'b0; on_p = 1'b0;
    repeat (2) @(posedge clk);
    count_en(100, c1, c2);
    chk("R2 rc cpu pulses", c1, 50);
    on_r = 1'b0; on_x = 1'b1; on_p = 1'b1;
    repeat (2) @(posedge clk);
    count_en(100, c1, c2);
    chk("R2 foreign ticks ignored", c1 + c2, 0);
    on_r = 1'b1;

    // R9 rejected writes keep settings
    chk("R9 err clear before", int'(cfg_err), 0);
    write_cfg(mk(2'd3, 2'd0, 1'b0, 5'd0, 4'd3, 5'd0, 2'd0, 3'd3, 2'd0));
    write_cfg(mk(2'd1, 2'd2, 1'b0, 5'd0, 4'd3, 5'd0, 2'd0, 3'd3, 2'd0));
    write_cfg(mk(2'd0, 2'd0, 1'b0, 5'd3, 4'd0, 5'd0, 2'd2, 3'd0, 2'd0));
    write_cfg(mk(2'd2, 2'd0, 1'b0, 5'd5, 4'd0, 5'd0, 2'd0, 3'd0, 2'd0));
    settle();
    chk("R9 err set", int'(cfg_err), 1);
    chk("R9 cpu_ratio kept", int'(cpu_ratio), 2);
    chk("R9 mem_ratio kept", int'(mem_ratio), 1);

    // R9 unused-path fields not checked
    write_cfg(mk(2'd0, 2'd2, 1'b1, 5'd15, 4'd5, 5'd3, 2'd0, 3'd7, 2'd1));
    settle();
    chk("R9 junk hs fields accepted", int'(cpu_ratio), 16);
    chk("R9 ahb slow /4", int'(ahb_ratio), 4);

    // random phase: R10 R11 R12 checked every cycle by the model
    rnd_ticks = 1'b1;
    for (int k = 0; k < 60; k++) begin
      write_cfg(rand_cfg());
      repeat (300 + $urandom % 1200) @(posedge clk);
    end
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule